// File: doc/BRIEF.md
# Binary GCD Iterative Unit

This unit finds the greatest common divisor of two unsigned operands with Stein's binary method. It uses only one-bit logical right shifts, subtraction, magnitude comparison and tests of the least significant bit. It has no divider and no remainder logic. A caller presents both operands with a one-cycle `start` pulse while `busy` is low. The unit then works through a short sequence of states and reports the answer on `result`, together with a single-cycle `done` pulse.

The controller has six states:
- `ST_IDLE`: waits for `start`.
- `ST_STRIP`: shifts both operands right while both are even, and counts each such shift in a factor-of-two counter `k`.
- `ST_NORM_A`: shifts the first operand right until it is odd.
- `ST_NORM_B`: shifts the second operand right until it is odd.
- `ST_SUBTR`: keeps the smaller operand and replaces the larger one by the difference.
- `ST_REPORT`: produces the odd divisor shifted left by `k`.

The transitions are:
- IDLE→STRIP on an accepted start with two nonzero operands.
- IDLE→REPORT on an accepted start with a zero operand.
- STRIP→NORM_A when at least one operand is odd.
- NORM_A→NORM_B when the first operand is odd.
- NORM_B→SUBTR when the second operand is odd.
- SUBTR→NORM_B on a nonzero difference.
- SUBTR→REPORT on a zero difference.
- REPORT→IDLE always.

Every state takes one cycle per visit.

Top module: `stein_gcd`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy`, `done` and `result` are all 0.
- R2: A `start` sampled while `busy` is low is accepted, and `busy` is high in the following cycle.
- R3: For two nonzero operands, `result` is their greatest common divisor. Examples: gcd(12,780)=12, gcd(780,12)=12, gcd(2048,16384)=2048, gcd(500005199,709)=1, gcd(554400,655200)=50400 and gcd(1048576,131072)=131072.
- R4: If exactly one operand is zero, `result` equals the other operand (gcd(0,12345)=12345). If both are zero, `result` is 0. In either case `done` rises two cycles after the start edge.
- R5: `done` is high for exactly one cycle, and in that cycle `busy` is already low.
- R6: `result` changes only in a cycle in which `done` is high, and otherwise holds its last value.
- R7: A `start` sampled while `busy` is high has no effect on the running computation or on its result.
- R8: For nonzero operands, the number of cycles from the start edge until `done` is high is 1 + (t+1) + (u+1) + Σ(v_i+2) + 1. Here t is the number of trailing zeros the two operands share, u is the number of extra trailing zeros of the first operand after that, and v_i is the number of trailing zeros of the second operand at the start of subtraction round i.
- R9: A `start` given in the cycle in which `done` is high is accepted as a new computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that launches a computation when idle |
| op_a | input | W | First unsigned operand |
| op_b | input | W | Second unsigned operand |
| busy | output | 1 | High while a computation is in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | W | Greatest common divisor of the last accepted pair |

## Verification
The bench runs these corner cases, each chosen for a specific failure:
- One zero operand. A unit that entered the shift loop with a zero operand would hang there.
- Two zero operands. A unit that mishandled this case would report a nonzero value or never pulse `done`.
- Operands that are powers of two and share up to 31 factors of two, such as 0x80000000 paired with itself. These expose a narrow or wrongly applied shift counter, which gives a truncated result.
- Swapped operand orders, and an operand pair that is equal. These expose a wrong swap or an off-by-one exit test, which would loop once too often or report the difference.
- A start given mid-run with different operands. A unit that accepted it would disturb both the timing and the result.
- A start given in the same cycle as `done`. A unit that dropped it would fall out of step with the model on `busy`.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STRIP,
        ST_NORM_A,
        ST_NORM_B,
        ST_SUBTR,
        ST_REPORT
    } gcd_state_e;
endpackage

// File: rtl/gcd_fsm.sv
module gcd_fsm
    import gcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       zero_in,
    input  logic       a_lsb,
    input  logic       b_lsb,
    input  logic       diff_zero,
    output gcd_state_e state
);
    gcd_state_e nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = zero_in ? ST_REPORT : ST_STRIP;
            ST_STRIP:  if (a_lsb || b_lsb) nxt = ST_NORM_A;
            ST_NORM_A: if (a_lsb) nxt = ST_NORM_B;
            ST_NORM_B: if (b_lsb) nxt = ST_SUBTR;
            ST_SUBTR:  nxt = diff_zero ? ST_REPORT : ST_NORM_B;
            ST_REPORT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
    import gcd_pkg::*;
#(
    parameter int W  = 32,
    parameter int KW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  gcd_state_e    state,
    input  logic          start,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    output logic [W-1:0]  opa,
    output logic [KW-1:0] shift_k,
    output logic          zero_in,
    output logic          a_lsb,
    output logic          b_lsb,
    output logic          diff_zero
);
    logic [W-1:0] opb;
    logic [W-1:0] small_v, big_v, diff_v;
    logic         swap;

    assign zero_in   = (in_a == '0) || (in_b == '0);
    assign a_lsb     = opa[0];
    assign b_lsb     = opb[0];
    assign swap      = opa > opb;
    assign small_v   = swap ? opb : opa;
    assign big_v     = swap ? opa : opb;
    assign diff_v    = big_v - small_v;
    assign diff_zero = (diff_v == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            opa     <= '0;
            opb     <= '0;
            shift_k <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        shift_k <= '0;
                        if (zero_in) begin
                            opa <= in_a | in_b;
                            opb <= '0;
                        end else begin
                            opa <= in_a;
                            opb <= in_b;
                        end
                    end
                end
                ST_STRIP: begin
                    if (!opa[0] && !opb[0]) begin
                        opa     <= opa >> 1;
                        opb     <= opb >> 1;
                        shift_k <= shift_k + 1'b1;
                    end
                end
                ST_NORM_A: if (!opa[0]) opa <= opa >> 1;
                ST_NORM_B: if (!opb[0]) opb <= opb >> 1;
                ST_SUBTR: begin
                    opa <= small_v;
                    opb <= diff_v;
                end
                ST_REPORT: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gcd_report.sv
module gcd_report #(
    parameter int W  = 32,
    parameter int KW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [W-1:0]  odd_part,
    input  logic [KW-1:0] shift_k,
    output logic [W-1:0]  result,
    output logic          done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= fire;
            if (fire) result <= odd_part << shift_k;
        end
    end
endmodule

// File: rtl/stein_gcd.sv
module stein_gcd
    import gcd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int KW = $clog2(W + 1);

    gcd_state_e    state;
    logic [W-1:0]  opa;
    logic [KW-1:0] shift_k;
    logic          zero_in, a_lsb, b_lsb, diff_zero;

    gcd_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .zero_in(zero_in),
        .a_lsb(a_lsb), .b_lsb(b_lsb), .diff_zero(diff_zero), .state(state)
    );

    gcd_datapath #(.W(W), .KW(KW)) u_dp (
        .clk(clk), .rst(rst), .state(state), .start(start),
        .in_a(op_a), .in_b(op_b), .opa(opa), .shift_k(shift_k),
        .zero_in(zero_in), .a_lsb(a_lsb), .b_lsb(b_lsb), .diff_zero(diff_zero)
    );

    gcd_report #(.W(W), .KW(KW)) u_rep (
        .clk(clk), .rst(rst), .fire(state == ST_REPORT),
        .odd_part(opa), .shift_k(shift_k), .result(result), .done(done)
    );

    // Output process
    always_comb begin
        busy = (state != ST_IDLE);
    end
endmodule

// File: rtl/gcd_checker.sv
module gcd_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !done |=> (done || $stable(result)));

    // R4
    zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (op_a == '0 || op_b == '0))
        |-> ##2 (done && result == $past(op_a | op_b, 2)));
endmodule

bind stein_gcd gcd_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .result(result)
);

// File: tb/tb_stein_gcd.sv
module tb_stein_gcd;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         busy, done;
    logic [W-1:0] result;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit seen_edge = 0;

    stein_gcd #(.W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: value and cycle count per the requirements
    function automatic void ref_gcd(input longint unsigned a_in, input longint unsigned b_in,
                                    output longint unsigned g, output int cyc);
        longint unsigned a = a_in, b = b_in, t;
        int k = 0;
        cyc = 1;
        if (a == 0 || b == 0) begin
            g = a | b;
            cyc += 1;
            return;
        end
        while ((a % 2 == 0) && (b % 2 == 0)) begin a = a / 2; b = b / 2; k++; cyc++; end
        cyc++;
        while (a % 2 == 0) begin a = a / 2; cyc++; end
        cyc++;
        do begin
            while (b % 2 == 0) begin b = b / 2; cyc++; end
            cyc += 2;
            if (a > b) begin t = a; a = b; b = t; end
            b = b - a;
        end while (b != 0);
        cyc++;
        g = (a << k) & 64'hFFFF_FFFF;
    endfunction

    int          rem = 0;
    logic        exp_done = 0;
    logic [W-1:0] exp_res = '0, pend_res = '0;

    always @(posedge clk) begin
        longint unsigned g;
        int c;
        seen_edge <= 1;
        cycles <= cycles + 1;
        if (rst) begin
            rem <= 0; exp_done <= 0; exp_res <= '0;
        end else begin
            exp_done <= 0;
            if (rem == 0) begin
                if (start) begin
                    ref_gcd(op_a, op_b, g, c);
                    pend_res <= g[W-1:0];
                    rem <= c - 1;
                end
            end else begin
                rem <= rem - 1;
                if (rem == 1) begin
                    exp_done <= 1;
                    exp_res  <= pend_res;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (seen_edge) begin
            check("R1/R2/R8 busy", {31'b0, busy}, {31'b0, (rem != 0)});
            check("R5/R8 done", {31'b0, done}, {31'b0, exp_done});
            check("R3/R6 result", result, exp_res);
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
        start = 1; op_a = a; op_b = b;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] g, input string tag);
        @(negedge clk);
        launch(a, b);
        wait_done();
        check(tag, result, g);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset busy", {31'b0, busy}, '0);
        check("R1 reset done", {31'b0, done}, '0);
        check("R1 reset result", result, '0);
        rst = 0;
        @(negedge clk);
        check("R1 after reset result", result, '0);

        run(12, 780, 12, "R3 gcd(12,780)");
        run(780, 12, 12, "R3 gcd(780,12)");
        run(2048, 16384, 2048, "R3 gcd(2048,16384)");
        run(500005199, 709, 1, "R3 gcd(500005199,709)");
        run(554400, 655200, 50400, "R3 gcd(554400,655200)");
        run(1048576, 131072, 131072, "R3 gcd(1048576,131072)");
        run(0, 12345, 12345, "R4 gcd(0,12345)");
        run(777, 0, 777, "R4 gcd(777,0)");
        run(0, 0, 0, "R4 gcd(0,0)");
        run(1, 1, 1, "R3 gcd(1,1)");
        run(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, "R3 R8 shared 2^31");
        run(32'hFFFF_FFFF, 32'hFFFF_FFFE, 1, "R3 R8 wide operands");
        run(96, 96, 96, "R3 equal operands");

        // R7: start while busy is ignored
        @(negedge clk);
        launch(554400, 655200);
        repeat (2) @(negedge clk);
        launch(7, 7);
        wait_done();
        check("R7 ignored mid-run start", result, 50400);

        // R9: start in the done cycle is accepted
        launch(0, 55);
        wait_done();
        launch(12, 780);
        check("R9 busy after back-to-back start", {31'b0, busy}, 32'd1);
        wait_done();
        check("R9 back-to-back result", result, 12);

        // R6: result holds while idle
        repeat (5) @(negedge clk);
        check("R6 result held", result, 12);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule